// File: doc/BRIEF.md
# Command Mailbox Sequencer

This block sits behind a pair of host-writable registers and turns a stream of register writes into single, well-formed operations. A write to the command register picks an operation code and empties a word collector. Each following write to the data register adds one 32-bit word to the collector. When the collected payload covers the byte length required by the current operation, the block pulses an execute strobe for one cycle. It presents the operation code and all collected words to an external handler. It captures the handler's 32-bit answer in a status register and goes back to idle.

The payload length of every operation comes from a parameter table, one byte count per code. Codes at or above the table size, and code zero, map to an idle entry that needs no payload. The idle entry always reports failure without calling the handler. Operations that need no payload run straight after the command write. While words are still outstanding, the status register holds a "not enough data" marker.

Top module: `cmd_mailbox_seq`

## Requirements
- R1: After synchronous reset the status reads 0 (succeeded), the execute strobe is low and no operation is pending.
- R2: A written code c with 0 < c < NUM_CMDS is taken as the current operation. Any other 32-bit value (0, NUM_CMDS or above, including 0xFFFFFFFF) selects the idle entry.
- R3: In the cycle after a command write, the status reads 0xFFFFFFFF (not enough data). It stays at that value while the payload is incomplete.
- R4: Data words are stored in arrival order. The k-th data word after a command appears at exec_words bits [32k+31:32k] when the strobe fires. Idle cycles between writes do not matter.
- R5: In the cycle after the write that brings the collected count times 4 to at least the operation's byte length, exec_stb is high with exec_cmd set to the code. In the cycle after that, status holds the exec_result value sampled with the strobe.
- R6: An operation with a zero byte length strobes in the cycle right after its command write.
- R7: The idle entry never raises exec_stb. When it completes, the status reads 1 (failed) two cycles after the write that armed it.
- R8: After an operation completes, the block is idle. A data write with no new command completes the idle entry: the status reads 1 and there is no strobe.
- R9: A command write abandons any partly collected operation, which never strobes. A command write also takes priority over a data write in the same cycle.
- R10: The collector holds the full payload of the longest operation (DEPTH words, taken from the table) and never counts past DEPTH.
- R11: With the default table, code 1 needs 6 words, code 4 needs 8, code 5 needs 3, code 7 needs 2, code 9 needs 1, and codes 2, 3, 6 and 8 need none.
- R12: exec_stb lasts exactly one cycle for each completed operation unless a new command write lands in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write enable |
| cmd_wdata | input | 32 | Command code written |
| data_we | input | 1 | Data register write enable |
| data_wdata | input | 32 | Payload word written |
| exec_stb | output | 1 | One-cycle execute strobe to the handler |
| exec_cmd | output | CMD_W (4) | Operation code presented with the strobe |
| exec_words | output | DEPTH*32 (256) | Collected payload, word 0 in the low bits |
| exec_result | input | 32 | Handler answer, valid in the strobe cycle |
| status | output | 32 | Registered command status (0 ok, 1 failed, 0xFFFFFFFF waiting) |

## Verification
A counter that is off by one shows up on the ports as a strobe that fires one write early or late. It also shows up as words that land in the wrong slot of exec_words at the strobe. A bench that knows each code's word count catches this on the first multi-word operation. A bad code decode or a stuck armed flag shows up as a strobe for an unknown code, a missing strobe for a valid one, or a status left at the waiting marker. All of these are visible two cycles after the last write. Random codes and payloads with random gaps, plus directed cases for restart, stray data writes and the longest payload, cover each of these paths.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] ST_OK   = 32'h0000_0000;
  localparam logic [WORD_W-1:0] ST_FAIL = 32'h0000_0001;
  localparam logic [WORD_W-1:0] ST_WAIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/mbx_len_lut.sv
module mbx_len_lut #(
  parameter int NUM_CMDS = 10,
  parameter int CMD_W    = 4,
  parameter logic [NUM_CMDS*8-1:0] CMD_BYTES = '0
) (
  input  logic [31:0]      raw_code,
  input  logic [CMD_W-1:0] cur_cmd,
  output logic [CMD_W-1:0] sel_cmd,
  output logic [7:0]       need_bytes
);
  // range check on the written code: only codes strictly between idle and the end
  always_comb begin
    if (raw_code != 32'd0 && raw_code < 32'(NUM_CMDS))
      sel_cmd = raw_code[CMD_W-1:0];
    else
      sel_cmd = '0;
  end

  // payload length lookup for the current operation
  always_comb begin
    need_bytes = 8'd0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (cur_cmd == CMD_W'(i))
        need_bytes = CMD_BYTES[i*8 +: 8];
    end
  end
endmodule

// File: rtl/mbx_collector.sv
module mbx_collector #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr,
  input  logic [31:0]        wdata,
  output logic [CNT_W-1:0]   cnt,
  output logic [DEPTH*32-1:0] words
);
  logic [CNT_W-1:0] base;
  logic             room;

  assign base = clr ? '0 : cnt;
  assign room = (base < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (wr && room)
      cnt <= base + 1'b1;
    else
      cnt <= base;
  end

  // one register per slot, no reset, written only at the current fill index
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (wr && room && base == CNT_W'(i))
        q <= wdata;
    end
    assign words[i*32 +: 32] = q;
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  p_append_r4: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr && cnt < CNT_W'(DEPTH)) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/cmd_mailbox_seq.sv
module cmd_mailbox_seq #(
  parameter int NUM_CMDS = 10,
  parameter logic [NUM_CMDS*8-1:0] CMD_BYTES =
    {8'd4, 8'd0, 8'd8, 8'd0, 8'd12, 8'd32, 8'd0, 8'd0, 8'd24, 8'd0},
  localparam int CMD_W = (NUM_CMDS > 2) ? $clog2(NUM_CMDS) : 1,
  localparam int DEPTH = calc_depth(),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_we,
  input  logic [31:0]         cmd_wdata,
  input  logic                data_we,
  input  logic [31:0]         data_wdata,
  output logic                exec_stb,
  output logic [CMD_W-1:0]    exec_cmd,
  output logic [DEPTH*32-1:0] exec_words,
  input  logic [31:0]         exec_result,
  output logic [31:0]         status
);
  import mbx_pkg::*;

  function automatic int calc_depth();
    int m;
    m = 0;
    for (int i = 0; i < NUM_CMDS; i++)
      if (int'(CMD_BYTES[i*8 +: 8]) > m) m = int'(CMD_BYTES[i*8 +: 8]);
    return (m < 4) ? 1 : (m + 3) / 4;
  endfunction

  logic [CMD_W-1:0] cur_cmd, sel_cmd;
  logic [7:0]       need_bytes;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      have_b;
  logic             armed, fire, col_clr, col_wr;

  mbx_len_lut #(.NUM_CMDS(NUM_CMDS), .CMD_W(CMD_W), .CMD_BYTES(CMD_BYTES)) u_lut (
    .raw_code(cmd_wdata), .cur_cmd(cur_cmd), .sel_cmd(sel_cmd), .need_bytes(need_bytes)
  );

  assign col_clr = cmd_we | fire;
  assign col_wr  = data_we & ~cmd_we;

  mbx_collector #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_col (
    .clk(clk), .rst(rst), .clr(col_clr), .wr(col_wr), .wdata(data_wdata),
    .cnt(cnt), .words(exec_words)
  );

  assign have_b   = 16'(cnt) << 2;
  assign fire     = armed && (have_b >= 16'(need_bytes));
  assign exec_stb = fire && (cur_cmd != '0);
  assign exec_cmd = cur_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cur_cmd <= '0;
      status  <= ST_OK;
    end else if (cmd_we) begin
      armed   <= 1'b1;
      cur_cmd <= sel_cmd;
      status  <= ST_WAIT;
    end else if (fire) begin
      status  <= (cur_cmd == '0) ? ST_FAIL : exec_result;
      cur_cmd <= '0;
      armed   <= data_we;
    end else if (data_we) begin
      armed   <= 1'b1;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (status == ST_OK && !exec_stb));

  p_wait_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> status == ST_WAIT);

  p_result_r5: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && !cmd_we) |=> status == $past(exec_result));

  p_idle_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && cur_cmd == '0 && !cmd_we) |=> status == ST_FAIL);

  p_single_r12: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && !cmd_we) |=> !exec_stb);
endmodule

// File: tb/cmd_mailbox_seq_bench.sv
module cmd_mailbox_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, cmd_we, data_we, exec_stb;
  logic [31:0]  cmd_wdata, data_wdata, exec_result, status;
  logic [3:0]   exec_cmd;
  logic [255:0] exec_words;

  int n_vec = 0, n_bad = 0, stb_cnt = 0;
  logic [3:0]   cap_cmd;
  logic [255:0] cap_words;
  logic [31:0]  wbuf [8];
  bit done = 0;

  function automatic int need_w(int c);
    case (c)
      1: return 6;
      4: return 8;
      5: return 3;
      7: return 2;
      9: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_valid(logic [31:0] c);
    return (c != 0) && (c < 32'd10);
  endfunction

  function automatic logic [31:0] hmodel(int c, logic [31:0] w0);
    if (c == 1) return 32'd1;
    return {4'(c), 28'h0} ^ ((need_w(c) > 0) ? w0 : 32'd0);
  endfunction

  assign exec_result = hmodel(int'(exec_cmd), exec_words[31:0]);

  cmd_mailbox_seq u_cmd_mailbox_seq (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .exec_stb(exec_stb),
    .exec_cmd(exec_cmd), .exec_words(exec_words), .exec_result(exec_result),
    .status(status)
  );

  always @(negedge clk) begin
    if (!rst && exec_stb) begin
      stb_cnt++;
      cap_cmd   = exec_cmd;
      cap_words = exec_words;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic put_cmd(input logic [31:0] c);
    cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic put_data(input logic [31:0] w, input int gap);
    repeat (gap) @(negedge clk);
    data_we = 1'b1; data_wdata = w;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [31:0] code, input int gap);
    int nw, base;
    nw = is_valid(code) ? need_w(int'(code)) : 0;
    for (int i = 0; i < nw; i++) wbuf[i] = $urandom;
    base = stb_cnt;
    put_cmd(code);
    chk("R3 waiting after command write", status, 32'hFFFF_FFFF);
    if (is_valid(code) && nw == 0) chk("R6 zero-payload strobe", 32'(exec_stb), 32'd1);
    for (int i = 0; i < nw; i++) begin
      put_data(wbuf[i], gap);
      if (i < nw - 1) chk("R3 waiting mid-payload", status, 32'hFFFF_FFFF);
    end
    @(negedge clk); @(negedge clk); #1;
    if (is_valid(code)) begin
      chk("R5 status holds handler result", status, hmodel(int'(code), wbuf[0]));
      chk("R12 one strobe per operation", 32'(stb_cnt - base), 32'd1);
      chk("R5 strobe code", 32'(cap_cmd), code);
      for (int i = 0; i < nw; i++)
        chk("R4 payload slot order", cap_words[i*32 +: 32], wbuf[i]);
    end else begin
      chk("R7 idle entry fails", status, 32'd1);
      chk("R2 rejected code gives no strobe", 32'(stb_cnt - base), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int base;
    logic [31:0] c;
    void'($urandom(32'd1234));
    rst = 1'b1; cmd_we = 0; data_we = 0; cmd_wdata = 0; data_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", status, 32'd0);
    chk("R1 reset strobe", 32'(exec_stb), 32'd0);

    run_cmd(32'd0, 0);           // R7 idle code
    run_cmd(32'd10, 0);          // R2 end code rejected
    run_cmd(32'hFFFF_FFFF, 0);   // R2 large code rejected
    run_cmd(32'd9, 0);           // R2 highest valid code
    run_cmd(32'd2, 0);           // R6 zero payload
    run_cmd(32'd1, 0);           // R11 six-word config
    chk("R11 code 1 reports failure", status, 32'd1);
    chk("R11 code 1 strobed with six words", cap_words[5*32 +: 32], wbuf[5]);
    run_cmd(32'd4, 2);           // R10 longest payload with gaps
    chk("R10 last collector slot", cap_words[7*32 +: 32], wbuf[7]);

    // R8 stray data word after completion
    base = stb_cnt;
    put_data(32'hA5A5_0001, 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R8 stray data fails", status, 32'd1);
    chk("R8 stray data no strobe", 32'(stb_cnt - base), 32'd0);

    // R9 restart abandons partial payload
    base = stb_cnt;
    put_cmd(32'd4);
    for (int i = 0; i < 3; i++) put_data(32'h1000 + 32'(i), 0);
    chk("R9 partial still waiting", status, 32'hFFFF_FFFF);
    run_cmd(32'd5, 1);
    chk("R9 abandoned op never strobed", 32'(stb_cnt - base), 32'd1);

    // R9 command wins over simultaneous data write
    base = stb_cnt;
    cmd_we = 1'b1; cmd_wdata = 32'd9; data_we = 1'b1; data_wdata = 32'h7777_0000;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk("R9 same-cycle data dropped", status, 32'hFFFF_FFFF);
    chk("R9 same-cycle no strobe", 32'(stb_cnt - base), 32'd0);
    wbuf[0] = 32'h0BAD_F00D;
    put_data(wbuf[0], 0);
    @(negedge clk); @(negedge clk); #1;
    chk("R5 code 9 after dropped word", status, hmodel(9, wbuf[0]));

    for (int k = 0; k < 250; k++) begin
      c = ($urandom % 8 == 0) ? $urandom : 32'($urandom % 13);
      run_cmd(c, int'($urandom % 3));
    end

    finish_run();
  end
endmodule